// File: doc/BRIEF.md
# Extender-Based Arithmetic-Logic Unit

A purely combinational arithmetic-logic unit for small operands (four bits by default). Each bit position has three parts: a full adder, a logic stage that prepares the adder's first input, and an arithmetic stage that prepares its second input. The carry ripples from bit 0 to the top bit. There is no case statement that picks among separate units. The operation comes from how the two stages shape the adder inputs, and from a carry-in derived from the control bits.

One mode line and a two-bit selector choose among eight operations. With the mode line high, the unit does decrement, add, subtract or increment. The carry out of the top bit gives the unsigned result status. The XOR of the carries out of the top two bits gives signed overflow. With the mode line low, the logic stage computes a bitwise function. The arithmetic stage then supplies zero and the carry-in is zero, so the adders only forward the logic value. Both flags are held at 0 in this mode.

Top module: `ext_alu`

## Requirements
- R1: With mode_arith=1 and sel=2'b00, result equals in_a minus 1 modulo 2^WIDTH, and carry_out is 1 exactly when in_a is not zero.
- R2: With mode_arith=1 and sel=2'b01, {carry_out, result} equals the WIDTH+1-bit sum in_a + in_b.
- R3: With mode_arith=1 and sel=2'b10, result equals in_a minus in_b modulo 2^WIDTH, and carry_out is 1 exactly when in_a >= in_b (unsigned).
- R4: With mode_arith=1 and sel=2'b11, result equals in_a plus 1 modulo 2^WIDTH, and carry_out is 1 exactly when in_a is all ones.
- R5: With mode_arith=0 and sel=2'b00, result is the bitwise inverse of in_a.
- R6: With mode_arith=0 and sel=2'b01, result is in_a AND in_b.
- R7: With mode_arith=0 and sel=2'b10, result equals in_a, whatever in_b is.
- R8: With mode_arith=0 and sel=2'b11, result is in_a OR in_b.
- R9: In arithmetic mode, carry_out is the carry out of the top adder bit. For the operand pairs above, it takes the value stated in R1 to R4.
- R10: In arithmetic mode, ovf_signed is 1 exactly when the signed (two's-complement) value of the operation falls outside the signed WIDTH-bit range: a-1, a+b, a-b or a+1, with both operands read as signed.
- R11: With mode_arith=0, carry_out and ovf_signed are both 0 for every operand and selector value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| mode_arith | input | 1 | 1 selects arithmetic operations, 0 selects bitwise ones |
| sel | input | 2 | Operation code within the chosen mode |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry out of the top bit (0 in bitwise mode) |
| ovf_signed | output | 1 | Two's-complement overflow (0 in bitwise mode) |

## Verification
The assertions are immediate checks on a combinational block. They assume every input is a known 0 or 1 and that the inputs are steady long enough for the ripple chain to settle before the outputs are judged. The stimulus meets both assumptions. It drives every input to a defined value from the start and changes inputs only after a rising clock edge. It reads the outputs half a period later, at the falling edge. The operand sweep covers all 256 pairs for each of the eight codes, so every signed and unsigned wrap point is reached inside these assumptions.

// File: rtl/ext_alu_pkg.sv
// Package: shared selector encodings for the extender-based ALU.
// Assumes a two-bit selector whose meaning depends on the mode line.
package ext_alu_pkg;
    // Arithmetic mode (mode line high)
    localparam logic [1:0] AR_DEC  = 2'b00;
    localparam logic [1:0] AR_ADD  = 2'b01;
    localparam logic [1:0] AR_SUB  = 2'b10;
    localparam logic [1:0] AR_INC  = 2'b11;
    // Bitwise mode (mode line low)
    localparam logic [1:0] LG_NOT  = 2'b00;
    localparam logic [1:0] LG_AND  = 2'b01;
    localparam logic [1:0] LG_PASS = 2'b10;
    localparam logic [1:0] LG_OR   = 2'b11;
endpackage

// File: rtl/alu_arith_stage.sv
// Module: per-bit arithmetic stage. Produces the second adder input from
// the operand bit. Gives ones for decrement, b for add, ~b for subtract and
// zero for increment. Gives zero whenever the mode line is low.
// Assumes the selector encoding in ext_alu_pkg.
module alu_arith_stage (
    input  logic       mode_arith,
    input  logic [1:0] sel,
    input  logic       b_bit,
    output logic       y_bit
);
    // Sum of products for the second adder operand
    always_comb begin
        y_bit = (mode_arith & ~sel[0] & ~b_bit) | (mode_arith & ~sel[1] & b_bit);
    end
endmodule

// File: rtl/alu_logic_stage.sv
// Module: per-bit logic stage. Produces the first adder input.
// Forwards a unchanged in arithmetic mode. In bitwise mode it gives
// NOT a, a AND b, a or a OR b, according to the selector.
// Assumes the selector encoding in ext_alu_pkg.
module alu_logic_stage
    import ext_alu_pkg::*;
(
    input  logic       mode_arith,
    input  logic [1:0] sel,
    input  logic       a_bit,
    input  logic       b_bit,
    output logic       x_bit
);
    // Select the bitwise function, or forward a in arithmetic mode
    always_comb begin
        if (mode_arith) begin
            x_bit = a_bit;
        end else begin
            case (sel)
                LG_NOT:  x_bit = ~a_bit;
                LG_AND:  x_bit = a_bit & b_bit;
                LG_PASS: x_bit = a_bit;
                default: x_bit = a_bit | b_bit;
            endcase
        end
    end
endmodule

// File: rtl/alu_full_add.sv
// Module: one-bit full adder cell of the ripple chain.
// Assumes nothing beyond known input values.
module alu_full_add (
    input  logic x_bit,
    input  logic y_bit,
    input  logic c_in,
    output logic s_bit,
    output logic c_out
);
    // Sum is the odd parity of the inputs; carry is the majority
    always_comb begin
        s_bit = x_bit ^ y_bit ^ c_in;
        c_out = (x_bit & y_bit) | (c_in & (x_bit ^ y_bit));
    end
endmodule

// File: rtl/ext_alu.sv
// Module: top of the extender-based ALU. One logic stage, one arithmetic
// stage and one full adder per bit, with a rippling carry. The carry-in
// is mode AND sel[1]. Both flags are held at zero in bitwise mode.
// Assumes WIDTH >= 2, so that two top carries exist for signed overflow.
module ext_alu #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             mode_arith,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             ovf_signed
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] x_vec;
    logic [WIDTH-1:0] y_vec;
    logic [WIDTH:0]   carry;

    // Carry-in is derived from the control bits
    always_comb begin
        carry[0] = mode_arith & sel[1];
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        alu_logic_stage u_le (
            .mode_arith (mode_arith),
            .sel        (sel),
            .a_bit      (in_a[i]),
            .b_bit      (in_b[i]),
            .x_bit      (x_vec[i])
        );
        alu_arith_stage u_ae (
            .mode_arith (mode_arith),
            .sel        (sel),
            .b_bit      (in_b[i]),
            .y_bit      (y_vec[i])
        );
        alu_full_add u_fa (
            .x_bit (x_vec[i]),
            .y_bit (y_vec[i]),
            .c_in  (carry[i]),
            .s_bit (result[i]),
            .c_out (carry[i+1])
        );
    end

    // Flags come from the top carries and are held at zero in bitwise mode
    always_comb begin
        carry_out  = mode_arith & carry[WIDTH];
        ovf_signed = mode_arith & (carry[WIDTH] ^ carry[TOP]);
    end
endmodule

// File: rtl/ext_alu_checker.sv
// Module: assertion checker for ext_alu, attached by bind. Compares the
// ports with integer arithmetic. Assumes the inputs hold known values.
module ext_alu_checker
    import ext_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic             mode_arith,
    input logic [1:0]       sel,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             ovf_signed
);
    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    // Immediate checks of each operation against the ports
    always_comb begin
        if (mode_arith && sel == AR_ADD) begin
            // R2
            add_sum_chk: assert ({carry_out, result} == ({1'b0, in_a} + {1'b0, in_b}));
            // R10
            add_overflow_chk: assert (ovf_signed ==
                ((in_a[MSB] == in_b[MSB]) && (result[MSB] != in_a[MSB])));
        end
        if (mode_arith && sel == AR_SUB) begin
            // R3
            sub_diff_chk: assert (result == in_a - in_b && carry_out == (in_a >= in_b));
            // R10
            sub_overflow_chk: assert (ovf_signed ==
                ((in_a[MSB] != in_b[MSB]) && (result[MSB] != in_a[MSB])));
        end
        if (mode_arith && sel == AR_DEC) begin
            // R1
            dec_value_chk: assert (result == in_a - ONE && carry_out == (in_a != '0));
        end
        if (mode_arith && sel == AR_INC) begin
            // R4
            inc_value_chk: assert (result == in_a + ONE && carry_out == (in_a == '1));
        end
        if (!mode_arith) begin
            // R11
            no_overflow_chk: assert (!carry_out && !ovf_signed);
        end
        if (!mode_arith && sel == LG_PASS) begin
            // R7
            pass_value_chk: assert (result == in_a);
        end
    end
endmodule

bind ext_alu ext_alu_checker #(.WIDTH(WIDTH)) u_ext_alu_checker (
    .in_a       (in_a),
    .in_b       (in_b),
    .mode_arith (mode_arith),
    .sel        (sel),
    .result     (result),
    .carry_out  (carry_out),
    .ovf_signed (ovf_signed)
);

// File: tb/ext_alu_bench.sv
// Bench: directed tests for ext_alu. Inputs change after a rising edge and
// outputs are read at the falling edge. Expected values come from
// integer models of the requirements.
module ext_alu_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         mode_arith = 1'b0;
    logic [1:0]   sel = 2'b00;
    logic [W-1:0] result;
    logic         carry_out;
    logic         ovf_signed;

    int checks = 0;
    int errors = 0;

    ext_alu #(.WIDTH(W)) u_ext_alu (
        .in_a       (in_a),
        .in_b       (in_b),
        .mode_arith (mode_arith),
        .sel        (sel),
        .result     (result),
        .carry_out  (carry_out),
        .ovf_signed (ovf_signed)
    );

    // Free-running clock that paces stimulus and sampling
    always #(CLK_PERIOD/2) clk = ~clk;

    // Compare one value and record a failure
    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Apply inputs after a rising edge and wait for the falling edge
    task automatic apply(input logic m, input logic [1:0] s, input int a, input int b);
        @(posedge clk);
        mode_arith = m;
        sel = s;
        in_a = W'(a);
        in_b = W'(b);
        @(negedge clk);
    endtask

    // Sweep one code over every operand pair, checking against the model
    task automatic sweep_code(input logic m, input logic [1:0] s, input string tag);
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                int sa;
                int sb;
                int full;
                int sv;
                int er;
                int ec;
                int eo;
                sa = (a > 7) ? a - 16 : a;
                sb = (b > 7) ? b - 16 : b;
                full = 0;
                sv = 0;
                er = 0;
                ec = 0;
                eo = 0;
                if (m) begin
                    case (s)
                        2'b00: begin full = a + 15;     sv = sa - 1;  end
                        2'b01: begin full = a + b;      sv = sa + sb; end
                        2'b10: begin full = a + (15 - b) + 1; sv = sa - sb; end
                        default: begin full = a + 1;    sv = sa + 1;  end
                    endcase
                    er = full % 16;
                    ec = full / 16;
                    eo = (sv > 7 || sv < -8) ? 1 : 0;
                end else begin
                    case (s)
                        2'b00: er = 15 - a;
                        2'b01: er = a & b;
                        2'b10: er = a;
                        default: er = a | b;
                    endcase
                end
                apply(m, s, a, b);
                cmp(tag, "result", int'(result), er);
                cmp(m ? "R9" : "R11", "carry_out", int'(carry_out), ec);
                cmp(m ? "R10" : "R11", "ovf_signed", int'(ovf_signed), eo);
            end
        end
    endtask

    // Known wrap points with expected values written out directly
    task automatic boundary_cases();
        apply(1'b1, 2'b01, 7, 1);
        cmp("R10", "add 7+1 ovf", int'(ovf_signed), 1);
        cmp("R2", "add 7+1 result", int'(result), 8);
        apply(1'b1, 2'b01, 15, 1);
        cmp("R9", "add 15+1 carry", int'(carry_out), 1);
        cmp("R10", "add 15+1 ovf", int'(ovf_signed), 0);
        apply(1'b1, 2'b10, 8, 1);
        cmp("R10", "sub 8-1 ovf", int'(ovf_signed), 1);
        cmp("R3", "sub 8-1 result", int'(result), 7);
        apply(1'b1, 2'b10, 0, 1);
        cmp("R9", "sub 0-1 carry", int'(carry_out), 0);
        cmp("R3", "sub 0-1 result", int'(result), 15);
        apply(1'b1, 2'b00, 0, 5);
        cmp("R1", "dec 0 result", int'(result), 15);
        cmp("R1", "dec 0 carry", int'(carry_out), 0);
        apply(1'b1, 2'b11, 15, 9);
        cmp("R4", "inc 15 result", int'(result), 0);
        cmp("R4", "inc 15 carry", int'(carry_out), 1);
        apply(1'b0, 2'b10, 9, 6);
        cmp("R7", "pass ignores b", int'(result), 9);
    endtask

    // Idle state with all inputs at zero
    task automatic idle_state();
        @(negedge clk);
        cmp("R5", "idle result", int'(result), 15);
        cmp("R11", "idle carry", int'(carry_out), 0);
        cmp("R11", "idle ovf", int'(ovf_signed), 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    // Scenario sequence
    initial begin
        idle_state();
        sweep_code(1'b1, 2'b00, "R1");
        sweep_code(1'b1, 2'b01, "R2");
        sweep_code(1'b1, 2'b10, "R3");
        sweep_code(1'b1, 2'b11, "R4");
        sweep_code(1'b0, 2'b00, "R5");
        sweep_code(1'b0, 2'b01, "R6");
        sweep_code(1'b0, 2'b10, "R7");
        sweep_code(1'b0, 2'b11, "R8");
        boundary_cases();
        summary();
        $finish;
    end
endmodule